// File: doc/BRIEF.md
# Multi-Format Serial Audio Deserializer

This block takes stereo audio from a three-wire serial link: a bit clock, a frame clock that tells left from right, and one data line. It runs on the bit clock. It samples the data line and the frame clock on each rising bit-clock edge. It rebuilds one left and one right sample for each frame. Each pair appears as two sign-extended parallel words together with a single-cycle strobe.

A two-bit format select chooses how words sit inside the frame:
- words start at the frame-clock edge;
- words start one bit clock after the edge;
- words end at the edge;
- a short frame pulse marks a left word that the right word follows directly.

A two-bit length select chooses 16, 20 or 24 significant bits. Data arrives most significant bit first, in two's complement.

After reset the block stays idle until the frame clock rises. It raises a qualifier output at that point, so that downstream logic starts on a frame boundary. A frame that was already under way at that point produces no output pair.

Top module: `audrx_serial_in`

## Requirements
- R1: While reset (rst_n sampled low) is applied, and in the first cycle after it, left_o and right_o read zero and pair_valid_o and active_o read low.
- R2: active_o goes high in the bit-clock cycle after the first rising edge that lrck shows after reset release. A rising edge here means a sample of 1 after a sample of 0, and the level held during reset counts as the previous sample. Once high, active_o stays high until the next reset.
- R3: fmt_sel=0 (edge-aligned): lrck low marks the left half and lrck high marks the right half. The word's most significant bit is the first bit sampled with the new lrck level. A half may last any number of bit clocks not smaller than the word length.
- R4: fmt_sel=1 (one-bit delay): the halves are as in R3, but the most significant bit is the second bit sampled with the new lrck level. Each half must last at least the word length plus one bit clock.
- R5: fmt_sel=2 (end-aligned): the halves are as in R3. The word is the last word-length bits sampled before lrck changes level. A half may last any number of bit clocks not smaller than the word length, including exactly the word length.
- R6: fmt_sel=3 (pulse-framed): lrck is high for one bit clock at the start of each frame. The left word's most significant bit is sampled in that same bit clock, and the right word's most significant bit follows the left word's least significant bit. Frames may be exactly two words long, back to back.
- R7: wlen_sel=0 selects 16 bits, 1 selects 20 bits, and 2 or 3 select 24 bits. Shorter words are sign-extended to the full output width.
- R8: Once both words of a frame are captured, pair_valid_o is high for exactly one cycle. left_o and right_o then hold that frame's words and do not change in any cycle where pair_valid_o is low.
- R9: pair_valid_o stays low while active_o is low. No pair is produced for a frame whose left word was not captured after active_o rose.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bclk | input | 1 | Bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lrck | input | 1 | Frame clock: channel select, or frame pulse in fmt_sel=3 |
| sdata | input | 1 | Serial audio data, MSB first |
| fmt_sel | input | 2 | Framing format code (R3 to R6) |
| wlen_sel | input | 2 | Word length code (R7) |
| left_o | output | OUT_W | Left sample of the last delivered pair |
| right_o | output | OUT_W | Right sample of the last delivered pair |
| pair_valid_o | output | 1 | One-cycle strobe per delivered pair |
| active_o | output | 1 | Set at the first frame-clock rise after reset |

## Verification
The bench builds the block with its default 24-bit output width. At that width the reserved length code, full-scale negative 16-bit words and unpadded 24-bit halves can all be observed at the outputs.

The bench drives each format at its tightest legal slot:
- 16-bit halves of 16 clocks in edge-aligned mode;
- 25-clock halves for 24-bit words with the one-bit delay;
- 24-clock halves in end-aligned mode;
- back-to-back 48-clock pulse frames.

It also drives looser slots, where padding bits would corrupt any misaligned capture. Some runs hold the frame clock high through reset, so the start qualifier must wait for a real rising edge.

// File: rtl/audrx_pkg.sv
package audrx_pkg;

   typedef enum logic [1:0] {
      FMT_EDGE  = 2'd0,
      FMT_DELAY = 2'd1,
      FMT_TAIL  = 2'd2,
      FMT_PULSE = 2'd3
   } audrx_fmt_e;

   localparam int unsigned AUDRX_MAX_WORD = 24;
   localparam int unsigned AUDRX_N_LENGTHS = 3;

   function automatic int unsigned audrx_len_of(input int unsigned idx);
      return 16 + 4 * idx;
   endfunction

   function automatic int unsigned audrx_len_idx(input logic [1:0] code);
      return (code == 2'd0) ? 0 : (code == 2'd1) ? 1 : 2;
   endfunction

endpackage

// File: rtl/audrx_frame_track.sv
module audrx_frame_track #(
   parameter int unsigned CW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lrck,
   input  logic          pulse_mode,
   output logic          lr_prev_o,
   output logic          start_o,
   output logic [CW-1:0] pos_o,
   output logic          run_o
);
   localparam logic [CW-1:0] POS_MAX = '1;

   logic [CW-1:0] cnt_q;
   logic          rise;

   assign rise    = lrck & ~lr_prev_o;
   assign start_o = pulse_mode ? rise : (lrck ^ lr_prev_o);
   assign pos_o   = start_o ? '0 : ((cnt_q == POS_MAX) ? cnt_q : cnt_q + CW'(1));

   always_ff @(posedge clk) begin
      lr_prev_o <= lrck;
      if (!rst_n) begin
         cnt_q <= POS_MAX;
         run_o <= 1'b0;
      end else begin
         cnt_q <= pos_o;
         if (rise) run_o <= 1'b1;
      end
   end

   // R2: the qualifier never drops outside reset
   assert_run_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run_o |=> run_o);

   // R2: the qualifier rises only after the frame clock went 0 -> 1
   assert_run_after_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_o) |-> ($past(lrck) && !$past(lrck, 2)));

endmodule

// File: rtl/audrx_word_pick.sv
module audrx_word_pick
   import audrx_pkg::*;
#(
   parameter int unsigned OUT_W = 24,
   parameter int unsigned CW    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sdata,
   input  logic [1:0]       fmt_sel,
   input  logic [1:0]       wlen_sel,
   input  logic             lrck,
   input  logic             lr_prev,
   input  logic             start,
   input  logic [CW-1:0]    pos,
   input  logic             run,
   output logic             cap_l_o,
   output logic             cap_r_o,
   output logic [OUT_W-1:0] word_o
);
   logic [OUT_W-1:0] sr_q;
   logic [OUT_W-1:0] sr_nx;
   logic [OUT_W-1:0] src;
   logic [CW-1:0]    nb, nb_m1, nb2_m1;
   logic [OUT_W-1:0] ext [AUDRX_N_LENGTHS];
   audrx_fmt_e       fmt;

   assign fmt    = audrx_fmt_e'(fmt_sel);
   assign sr_nx  = {sr_q[OUT_W-2:0], sdata};
   assign nb     = CW'(audrx_len_of(audrx_len_idx(wlen_sel)));
   assign nb_m1  = nb - CW'(1);
   assign nb2_m1 = {nb[CW-2:0], 1'b0} - CW'(1);

   always_ff @(posedge clk) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= sr_nx;
   end

   always_comb begin
      cap_l_o = 1'b0;
      cap_r_o = 1'b0;
      src     = sr_nx;
      case (fmt)
         FMT_EDGE: begin
            cap_l_o = run && (pos == nb_m1) && !lrck;
            cap_r_o = run && (pos == nb_m1) && lrck;
         end
         FMT_DELAY: begin
            cap_l_o = run && (pos == nb) && !lrck;
            cap_r_o = run && (pos == nb) && lrck;
         end
         FMT_TAIL: begin
            src     = sr_q;
            cap_l_o = run && start && !lr_prev;
            cap_r_o = run && start && lr_prev;
         end
         FMT_PULSE: begin
            cap_l_o = run && (pos == nb_m1);
            cap_r_o = run && (pos == nb2_m1);
         end
      endcase
   end

   for (genvar g = 0; g < AUDRX_N_LENGTHS; g++) begin : g_ext
      localparam int unsigned LW = audrx_len_of(g);
      assign ext[g] = OUT_W'(signed'(src[LW-1:0]));
   end

   assign word_o = ext[audrx_len_idx(wlen_sel)];

endmodule

// File: rtl/audrx_pair_out.sv
module audrx_pair_out #(
   parameter int unsigned OUT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_l,
   input  logic             cap_r,
   input  logic [OUT_W-1:0] word,
   output logic [OUT_W-1:0] left_o,
   output logic [OUT_W-1:0] right_o,
   output logic             valid_o
);
   logic [OUT_W-1:0] hold_l_q;
   logic             have_l_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_l_q <= '0;
         have_l_q <= 1'b0;
         left_o   <= '0;
         right_o  <= '0;
         valid_o  <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (cap_l) begin
            hold_l_q <= word;
            have_l_q <= 1'b1;
         end
         if (cap_r) begin
            have_l_q <= 1'b0;
            if (have_l_q) begin
               left_o  <= hold_l_q;
               right_o <= word;
               valid_o <= 1'b1;
            end
         end
      end
   end

   // R8: strobe lasts one cycle
   assert_single_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R8: published words only move together with the strobe
   assert_hold_words_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(left_o) && $stable(right_o)));

endmodule

// File: rtl/audrx_serial_in.sv
module audrx_serial_in
   import audrx_pkg::*;
#(
   parameter int unsigned OUT_W = 24
) (
   input  logic             bclk,
   input  logic             rst_n,
   input  logic             lrck,
   input  logic             sdata,
   input  logic [1:0]       fmt_sel,
   input  logic [1:0]       wlen_sel,
   output logic [OUT_W-1:0] left_o,
   output logic [OUT_W-1:0] right_o,
   output logic             pair_valid_o,
   output logic             active_o
);
   localparam int unsigned CW = $clog2(2 * OUT_W + 1);

   if (OUT_W < AUDRX_MAX_WORD) begin : g_bad_width
      $error("audrx_serial_in: OUT_W must cover the longest word");
   end

   logic          lr_prev, start, cap_l, cap_r;
   logic [CW-1:0] pos;
   logic [OUT_W-1:0] word;

   audrx_frame_track #(.CW(CW)) u_track (
      .clk        (bclk),
      .rst_n      (rst_n),
      .lrck       (lrck),
      .pulse_mode (fmt_sel == FMT_PULSE),
      .lr_prev_o  (lr_prev),
      .start_o    (start),
      .pos_o      (pos),
      .run_o      (active_o)
   );

   audrx_word_pick #(.OUT_W(OUT_W), .CW(CW)) u_pick (
      .clk      (bclk),
      .rst_n    (rst_n),
      .sdata    (sdata),
      .fmt_sel  (fmt_sel),
      .wlen_sel (wlen_sel),
      .lrck     (lrck),
      .lr_prev  (lr_prev),
      .start    (start),
      .pos      (pos),
      .run      (active_o),
      .cap_l_o  (cap_l),
      .cap_r_o  (cap_r),
      .word_o   (word)
   );

   audrx_pair_out #(.OUT_W(OUT_W)) u_out (
      .clk     (bclk),
      .rst_n   (rst_n),
      .cap_l   (cap_l),
      .cap_r   (cap_r),
      .word    (word),
      .left_o  (left_o),
      .right_o (right_o),
      .valid_o (pair_valid_o)
   );

   // R9: nothing is delivered before the start qualifier
   assert_quiet_until_active_R9: assert property (@(posedge bclk) disable iff (!rst_n)
      !active_o |-> !pair_valid_o);

endmodule

// File: tb/audrx_serial_in_bench.sv
module audrx_serial_in_bench;
   localparam int CLK_PERIOD = 10;
   localparam int OUT_W      = 24;

   logic bclk = 1'b0, rst_n = 1'b0, lrck = 1'b0, sdata = 1'b0;
   logic [1:0] fmt_sel = 2'd0, wlen_sel = 2'd2;
   logic [OUT_W-1:0] left_o, right_o;
   logic pair_valid_o, active_o;

   audrx_serial_in #(.OUT_W(OUT_W)) u_audrx_serial_in (
      .bclk(bclk), .rst_n(rst_n), .lrck(lrck), .sdata(sdata),
      .fmt_sel(fmt_sel), .wlen_sel(wlen_sel),
      .left_o(left_o), .right_o(right_o),
      .pair_valid_o(pair_valid_o), .active_o(active_o));

   always #(CLK_PERIOD/2) bclk = ~bclk;

   int n_checks = 0, n_fail = 0;
   logic [OUT_W-1:0] exp_l[$], exp_r[$];
   logic [OUT_W-1:0] last_l, last_r;
   string cur_tag = "";
   bit mon_on = 0;
   logic m_run = 0, m_prev = 0;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [OUT_W-1:0] sx(input logic [OUT_W-1:0] v, input int n);
      logic signed [31:0] t;
      t = signed'({8'b0, v} << (32 - n));
      return OUT_W'(t >>> (32 - n));
   endfunction

   // reference for the start qualifier (R2)
   always @(posedge bclk) begin
      if (!rst_n) m_run <= 1'b0;
      else if (lrck && !m_prev) m_run <= 1'b1;
      m_prev <= lrck;
   end

   // per-cycle comparison against the model
   always @(negedge bclk) begin
      if (mon_on) begin
         check("R2 active", active_o, m_run);
         if (!active_o) check("R9 early strobe", pair_valid_o, 1'b0);
         if (pair_valid_o) begin
            if (exp_l.size() == 0) check({cur_tag, " R9 unexpected pair"}, 1, 0);
            else begin
               check({cur_tag, " R8 left"}, left_o, exp_l.pop_front());
               check({cur_tag, " R8 right"}, right_o, exp_r.pop_front());
            end
         end else begin
            check("R8 left held", left_o, last_l);
            check("R8 right held", right_o, last_r);
         end
         last_l = left_o;
         last_r = right_o;
      end
   end

   task automatic put_bit(input logic l, input logic d);
      @(negedge bclk);
      lrck  = l;
      sdata = d;
   endtask

   task automatic do_reset(input logic lr_level);
      mon_on = 0;
      @(negedge bclk);
      rst_n = 0; lrck = lr_level; sdata = 0;
      exp_l.delete(); exp_r.delete();
      repeat (4) @(negedge bclk);
      check("R1 left", left_o, 0);
      check("R1 right", right_o, 0);
      check("R1 valid", pair_valid_o, 0);
      check("R1 active", active_o, 0);
      rst_n = 1;
      @(negedge bclk);
      check("R1 active after release", active_o, 0);
      check("R1 valid after release", pair_valid_o, 0);
      last_l = left_o; last_r = right_o;
      mon_on = 1;
      repeat (5) put_bit(lr_level, 1'b0);
      repeat (2) put_bit(1'b0, 1'b1);
   endtask

   task automatic send_frame(input int fmt, input int n, input int slot,
                             input logic [OUT_W-1:0] l, input logic [OUT_W-1:0] r,
                             input bit expect_pair);
      if (expect_pair) begin
         exp_l.push_back(sx(l, n));
         exp_r.push_back(sx(r, n));
      end
      if (fmt == 3) begin
         for (int i = 0; i < slot; i++) begin
            logic d;
            if (i < n)          d = l[n-1-i];
            else if (i < 2 * n) d = r[2*n-1-i];
            else                d = (i % 3 == 1);
            put_bit(i == 0, d);
         end
      end else begin
         for (int h = 0; h < 2; h++) begin
            logic [OUT_W-1:0] w;
            w = (h == 0) ? l : r;
            for (int i = 0; i < slot; i++) begin
               logic d;
               d = (i % 3 == 1);
               if (fmt == 0 && i < n) d = w[n-1-i];
               if (fmt == 1 && i >= 1 && i <= n) d = w[n-i];
               if (fmt == 2 && i >= slot - n) d = w[slot-1-i];
               put_bit(h[0], d);
            end
         end
      end
   endtask

   task automatic run_case(input int fmt, input int wcode, input int n, input int slot,
                           input logic lr_level, input string tag);
      logic [OUT_W-1:0] mask, l, r;
      cur_tag  = tag;
      fmt_sel  = 2'(fmt);
      wlen_sel = 2'(wcode);
      do_reset(lr_level);
      mask = OUT_W'((32'd1 << n) - 1);
      for (int f = 0; f < 6; f++) begin
         l = OUT_W'($urandom) & mask;
         r = OUT_W'($urandom) & mask;
         if (f == 1) begin
            l = OUT_W'(1) << (n - 1);
            r = mask >> 1;
         end
         if (f == 2) begin
            l = mask;
            r = '0;
         end
         send_frame(fmt, n, slot, l, r, (fmt == 3) || (f >= 1));
      end
      repeat (80) put_bit(1'b0, 1'b0);
      check({tag, " R9 pairs left over"}, exp_l.size(), 0);
   endtask

   task automatic summary;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge bclk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      run_case(0, 2, 24, 32, 1'b0, "R3 R7 edge24");
      run_case(0, 0, 16, 16, 1'b1, "R3 R7 edge16 tight");
      run_case(1, 1, 20, 32, 1'b0, "R4 R7 delay20");
      run_case(1, 2, 24, 25, 1'b1, "R4 delay24 tight");
      run_case(2, 1, 20, 32, 1'b1, "R5 R7 tail20");
      run_case(2, 2, 24, 24, 1'b0, "R5 tail24 tight");
      run_case(3, 0, 16, 40, 1'b0, "R6 R7 pulse16");
      run_case(3, 3, 24, 48, 1'b1, "R6 R7 pulse24 code3 back-to-back");
      mon_on = 0;
      summary();
      $finish;
   end
endmodule